// File: doc/BRIEF.md
# Part Number String Decoder

This block reads a board part-number record out of nonvolatile memory, one 16-bit word per request on a simple request/acknowledge read port, and delivers the record as a byte string on a valid/ready stream. The string always ends with a zero byte. A caller pulses `start` and gives the size of its destination buffer. When the sequence ends, `done` pulses for one cycle together with a result code.

The first two words come from two fixed record addresses. If the first word differs from a guard value, the record is packed: the two words hold ten hex digits, and the block turns them into an 11-byte text with a dash and an embedded zero. If the first word equals the guard, the second word points at a length word. The string words follow the length word, and each string word gives two characters. The block checks the length and the buffer size before it emits anything, and it stops at the first failed read.

Top module: `part_string_decoder`

## Requirements
- R1: During and right after reset, `busy`, `rd_req`, `out_valid` and `done` are low.
- R2: A read holds `rd_req` high with a stable `rd_addr` until `rd_ack`. The first read of a run is at `OFF_A` and the second at `OFF_B`.
- R3: If the word at `OFF_A` differs from `GUARD`, the output is 11 bytes: the four nibbles of that word, most significant first, then the top two nibbles of the `OFF_B` word, then 0x2D ('-'), then 0x00, then the low two nibbles of the `OFF_B` word, then 0x00. Each nibble becomes ASCII 0x30+n for n<10 and 0x37+n for n of 10 to 15.
- R4: In the packed format, a `buf_size` below 11 ends the run with code 3 and emits no bytes.
- R5: In the pointer format, the word at address `OFF_B` word (the pointer) is the length L. An L of 0x0000 or 0xFFFF ends the run with code 2 and emits no bytes.
- R6: In the pointer format, a `buf_size` below 2*L-1 ends the run with code 3 and emits no bytes.
- R7: In the pointer format, L-1 string words are read from pointer+1 upward, with addresses wrapping modulo 2^AW. Each word emits its high byte and then its low byte. One 0x00 byte follows the last word. When L=1, only the 0x00 is emitted.
- R8: A read acknowledged with `rd_err` ends the run at once with code 1. Bytes emitted before it stay emitted.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` does not change.
- R10: `done` is a one-cycle pulse, and `busy` is low in the following cycle. `err_code` is 0 for success, 1 for a read error, 2 for an invalid section and 3 for insufficient space.
- R11: `buf_size` is sampled at `start`. A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode run |
| buf_size | input | BW | Destination buffer size in bytes, sampled at start |
| busy | output | 1 | A run is in progress |
| rd_req | output | 1 | Word read request |
| rd_addr | output | AW | Word address of the request |
| rd_ack | input | 1 | Read completed this cycle |
| rd_err | input | 1 | Read failed, valid with rd_ack |
| rd_data | input | 16 | Read word, valid with rd_ack |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | Result code, valid with done |

## Verification
The hardest case to reach is a read failure partway through a pointer string, after some bytes have already gone out. The bench memory model has a programmable faulty address. It places that address on the third word of a five-word record, so the run has to stop after exactly two string bytes. The stimulus table also puts the pointer near the top of a small memory so that the string addresses wrap. It throttles `out_ready` on alternate vectors to hold bytes under backpressure. In directed tests, `buf_size` is changed and `start` is pulsed again in the middle of a run.

// File: rtl/part_string_decoder.sv
module part_string_decoder #(
  parameter int AW = 16,
  parameter int BW = 16,
  parameter logic [15:0] GUARD = 16'hFAFA,
  parameter logic [AW-1:0] OFF_A = AW'(8),
  parameter logic [AW-1:0] OFF_B = AW'(9)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] buf_size,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic          rd_err,
  input  logic [15:0]   rd_data,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  input  logic          out_ready,
  output logic          done,
  output logic [1:0]    err_code
);
  localparam logic [1:0] E_OK = 2'd0, E_READ = 2'd1, E_SECT = 2'd2, E_SPACE = 2'd3;
  localparam logic [3:0] LEG_LAST = 4'd10;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_A, S_RD_B, S_RD_LEN, S_RD_STR,
    S_LEG, S_HI, S_LO, S_NUL, S_DONE
  } state_t;

  state_t        state;
  logic [15:0]   word;
  logic [AW-1:0] ptr;
  logic [15:0]   cnt;
  logic [3:0]    idx;
  logic [BW-1:0] bsz;
  logic [1:0]    err;

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + 8'(n)) : (8'h37 + 8'(n));
  endfunction

  logic [15:0] pw;
  logic [7:0]  leg_byte;
  logic [31:0] need;
  logic        small_buf;

  assign pw = 16'(ptr);
  assign need = {15'd0, rd_data, 1'b0} - 32'd1;
  assign small_buf = 32'(bsz) < need;

  always_comb begin
    case (idx)
      4'd0:    leg_byte = hexc(word[15:12]);
      4'd1:    leg_byte = hexc(word[11:8]);
      4'd2:    leg_byte = hexc(word[7:4]);
      4'd3:    leg_byte = hexc(word[3:0]);
      4'd4:    leg_byte = hexc(pw[15:12]);
      4'd5:    leg_byte = hexc(pw[11:8]);
      4'd6:    leg_byte = 8'h2D;
      4'd8:    leg_byte = hexc(pw[7:4]);
      4'd9:    leg_byte = hexc(pw[3:0]);
      default: leg_byte = 8'h00;
    endcase
  end

  assign busy      = state != S_IDLE;
  assign done      = state == S_DONE;
  assign err_code  = err;
  assign rd_req    = state inside {S_RD_A, S_RD_B, S_RD_LEN, S_RD_STR};
  assign out_valid = state inside {S_LEG, S_HI, S_LO, S_NUL};

  always_comb begin
    case (state)
      S_RD_A:  rd_addr = OFF_A;
      S_RD_B:  rd_addr = OFF_B;
      default: rd_addr = ptr;
    endcase
  end

  always_comb begin
    case (state)
      S_LEG:   out_byte = leg_byte;
      S_HI:    out_byte = word[15:8];
      S_LO:    out_byte = word[7:0];
      default: out_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      word  <= '0;
      ptr   <= '0;
      cnt   <= '0;
      idx   <= '0;
      bsz   <= '0;
      err   <= E_OK;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          bsz   <= buf_size;
          err   <= E_OK;
          state <= S_RD_A;
        end
        S_RD_A: if (rd_ack) begin
          if (rd_err) begin
            err <= E_READ; state <= S_DONE;
          end else begin
            word <= rd_data; state <= S_RD_B;
          end
        end
        S_RD_B: if (rd_ack) begin
          ptr <= AW'(rd_data);
          if (rd_err) begin
            err <= E_READ; state <= S_DONE;
          end else if (word != GUARD) begin
            idx <= '0;
            if (32'(bsz) < 32'd11) begin
              err <= E_SPACE; state <= S_DONE;
            end else begin
              state <= S_LEG;
            end
          end else begin
            state <= S_RD_LEN;
          end
        end
        S_RD_LEN: if (rd_ack) begin
          if (rd_err) begin
            err <= E_READ; state <= S_DONE;
          end else if (rd_data == 16'h0000 || rd_data == 16'hFFFF) begin
            err <= E_SECT; state <= S_DONE;
          end else if (small_buf) begin
            err <= E_SPACE; state <= S_DONE;
          end else begin
            cnt   <= rd_data - 16'd1;
            ptr   <= ptr + AW'(1);
            state <= (rd_data == 16'd1) ? S_NUL : S_RD_STR;
          end
        end
        S_RD_STR: if (rd_ack) begin
          if (rd_err) begin
            err <= E_READ; state <= S_DONE;
          end else begin
            word <= rd_data; state <= S_HI;
          end
        end
        S_LEG: if (out_ready) begin
          if (idx == LEG_LAST) state <= S_DONE;
          else idx <= idx + 4'd1;
        end
        S_HI: if (out_ready) state <= S_LO;
        S_LO: if (out_ready) begin
          ptr   <= ptr + AW'(1);
          cnt   <= cnt - 16'd1;
          state <= (cnt == 16'd1) ? S_NUL : S_RD_STR;
        end
        S_NUL: if (out_ready) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/part_string_decoder_chk.sv
module part_string_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          out_valid,
  input logic [7:0]    out_byte,
  input logic          out_ready,
  input logic          done
);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R11
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !rd_req);
endmodule

bind part_string_decoder part_string_decoder_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rd_req(rd_req),
  .rd_addr(rd_addr), .rd_ack(rd_ack), .out_valid(out_valid),
  .out_byte(out_byte), .out_ready(out_ready), .done(done)
);

// File: tb/tb_part_string_decoder.sv
module tb_part_string_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] GUARD = 16'hFAFA;
  localparam logic [15:0] OFF_A = 16'h0008;
  localparam logic [15:0] OFF_B = 16'h0009;
  localparam logic [15:0] NOERR = 16'hFFFF;
  localparam int NV = 13;

  // {w0, w1, len_word, buf_size, fail_addr}
  localparam logic [79:0] VEC [NV] = '{
    {16'h1234, 16'hABCD, 16'h0000, 16'd11, NOERR},
    {16'h9AF0, 16'h5E07, 16'h0000, 16'd20, NOERR},
    {16'h1234, 16'hABCD, 16'h0000, 16'd10, NOERR},
    {GUARD,    16'h0040, 16'h0004, 16'd7,  NOERR},
    {GUARD,    16'h0040, 16'h0004, 16'd6,  NOERR},
    {GUARD,    16'h0060, 16'h0000, 16'd99, NOERR},
    {GUARD,    16'h0060, 16'hFFFF, 16'd99, NOERR},
    {GUARD,    16'h0070, 16'h0001, 16'd1,  NOERR},
    {GUARD,    16'h0040, 16'h0004, 16'd9,  OFF_A},
    {16'h1234, 16'hABCD, 16'h0000, 16'd11, OFF_B},
    {GUARD,    16'h0040, 16'h0004, 16'd9,  16'h0040},
    {GUARD,    16'h0040, 16'h0005, 16'd9,  16'h0042},
    {GUARD,    16'h00FE, 16'h0003, 16'd5,  NOERR}
  };
  localparam logic [1:0] VERR [NV] = '{2'd0, 2'd0, 2'd3, 2'd0, 2'd3, 2'd2, 2'd2,
                                       2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0};

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] buf_size = '0;
  logic busy, rd_req, rd_ack = 0, rd_err = 0, out_valid, out_ready, done;
  logic [15:0] rd_addr, rd_data = '0;
  logic [7:0] out_byte;
  logic [1:0] err_code;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [256];
  logic [15:0] fail_addr = NOERR;
  logic stall = 0;
  logic [1:0] ph = '0;
  logic [7:0] got [1024];
  int gotn = 0;
  logic [7:0] exp_b [64];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  part_string_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_size(buf_size), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
    .rd_data(rd_data), .out_valid(out_valid), .out_byte(out_byte),
    .out_ready(out_ready), .done(done), .err_code(err_code)
  );

  assign out_ready = stall ? ph[1] : 1'b1;

  always @(posedge clk) begin
    ph <= ph + 2'd1;
    rd_ack <= rd_req && !rd_ack;
    rd_data <= mem[rd_addr[7:0]];
    rd_err <= rd_req && !rd_ack && (rd_addr == fail_addr);
    if (out_valid && out_ready) begin
      got[gotn % 1024] <= out_byte;
      gotn <= gotn + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
  endfunction

  task automatic push(input logic [7:0] b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  // Expected byte string from R3, R7, R8
  task automatic model(input logic [15:0] w0, input logic [15:0] w1, input int bsz);
    logic [15:0] len, a, w;
    exp_n = 0;
    if (fail_addr == OFF_A || fail_addr == OFF_B) return;
    if (w0 != GUARD) begin
      if (bsz < 11) return;
      push(hx(w0[15:12])); push(hx(w0[11:8])); push(hx(w0[7:4])); push(hx(w0[3:0]));
      push(hx(w1[15:12])); push(hx(w1[11:8])); push(8'h2D); push(8'h00);
      push(hx(w1[7:4])); push(hx(w1[3:0])); push(8'h00);
      return;
    end
    if (fail_addr == w1) return;
    len = mem[w1[7:0]];
    if (len == 0 || len == 16'hFFFF || bsz < 2*int'(len) - 1) return;
    for (int k = 1; k < int'(len); k++) begin
      a = w1 + 16'(k);
      if (a == fail_addr) return;
      w = mem[a[7:0]];
      push(w[15:8]); push(w[7:0]);
    end
    push(8'h00);
  endtask

  task automatic load(input logic [79:0] v);
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h5A, 8'(i) + 8'h30};
    mem[OFF_A[7:0]] = v[79:64];
    mem[OFF_B[7:0]] = v[63:48];
    mem[v[55:48]] = v[47:32];
    fail_addr = v[15:0];
  endtask

  task automatic wait_done(output logic [1:0] code);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    code = err_code;
    if (t >= 2000) check(0, "R10", "watchdog, no done", 0, 1);
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [15:0] b);
    buf_size = b; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic compare(input int base, input string req);
    bit ok = (gotn - base) == exp_n;
    check(ok, req, "byte count", gotn - base, exp_n);
    if (ok) for (int i = 0; i < exp_n; i++)
      if (got[(base + i) % 1024] != exp_b[i]) begin
        check(0, req, $sformatf("byte %0d", i), got[(base + i) % 1024], exp_b[i]);
        return;
      end
    check(1, req, "bytes", 0, 0);
  endtask

  initial begin
    logic [1:0] code;
    int base;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !rd_req && !out_valid && !done, "R1", "idle in reset",
          {busy, rd_req, out_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !rd_req && !out_valid && !done, "R1", "idle after reset",
          {busy, rd_req, out_valid, done}, 0);

    // R3 R4 R5 R6 R7 R8 R9 R10 table walk
    for (int v = 0; v < NV; v++) begin
      stall = v[0];
      load(VEC[v]);
      model(VEC[v][79:64], VEC[v][63:48], int'(VEC[v][31:16]));
      base = gotn;
      pulse_start(VEC[v][31:16]);
      wait_done(code);
      check(code == VERR[v], "R10", $sformatf("vector %0d code", v), code, VERR[v]);
      compare(base, "R7");
    end
    stall = 0;

    // R2 first read address
    load({16'h1234, 16'hABCD, 16'h0, 16'd11, NOERR});
    buf_size = 16'd11; start = 1;
    @(negedge clk); start = 0;
    check(rd_req && rd_addr == OFF_A, "R2", "first address", rd_addr, OFF_A);
    @(negedge clk); @(negedge clk);
    check(rd_req && rd_addr == OFF_B, "R2", "second address", rd_addr, OFF_B);
    wait_done(code);

    // R11 buf_size sampled at start, start ignored while busy
    load({GUARD, 16'h0040, 16'h0004, 16'd7, NOERR});
    model(GUARD, 16'h0040, 7);
    base = gotn;
    pulse_start(16'd7);
    buf_size = 16'd0;
    repeat (4) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done(code);
    check(code == 2'd0, "R11", "code with buf changed", code, 0);
    compare(base, "R11");
    repeat (10) @(negedge clk);
    check(!busy && !done && gotn == base + exp_n, "R11", "no second run",
          {busy, done}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule